// File: doc/BRIEF.md
# Lookahead Priority Slice

This block is one slice of a one-hot priority encoder built from identical slices. It takes a vector of request bits and a single lookahead input. The lookahead input tells the slice that some request is already pending in an earlier slice, and earlier slices have higher priority. The slice returns a one-hot grant vector that marks its lowest-index request. It also returns a lookahead output that feeds the next slice in the chain. The logic is purely combinational.

Inside, the slice is split into equal sub-blocks of `SUB_W` bits each, and there are `SUB_CNT` of them. By default there are two 4-bit halves. Each sub-block forms its grants from a product term per bit: the bit's own request, the inverted requests below it in the same sub-block, and an inverted block signal. The block signal is a lookahead. It is the OR of the requests in all lower sub-blocks together with the lookahead input. With the default split, this is the internal second-level lookahead that gates the upper half.

The first slice of a chain gets its lookahead input tied to 0. Each later slice takes its lookahead input from the previous slice's lookahead output. Binary index encoding, pipelining and any network that skips slices are left to the surrounding logic.

Top module: `pe_la_slice`

## Requirements
- R1: With the lookahead input at 0, the grant vector is the lowest set bit of the request vector: bit i is 1 exactly when request i is 1 and every request below index i is 0. Index 0 has the highest priority.
- R2: The lookahead output is 1 exactly when the lookahead input is 1 or at least one request bit of the slice is 1.
- R3: A request in the upper sub-block is never granted while any request in a lower sub-block is 1. With the default split, bits 4 to 7 are gated by the OR of bits 0 to 3 together with the lookahead input.
- R4: With the lookahead input at 1, every grant bit is 0 for any request pattern.
- R5: At most one grant bit is 1 at any time.
- R6: With all requests at 0 and the lookahead input at 0, the grant vector is all zeros and the lookahead output is 0.
- R7: When two slices are chained, the second is fed by the first's lookahead output and the first has its lookahead input at 0. The two 8-bit grant vectors together are then the lowest set bit of the 16-bit request vector formed by the two request vectors, with the first slice holding bits 0 to 7.
- R8: The grant and lookahead results depend only on the slice width `SUB_W*SUB_CNT`, not on how it is split into sub-blocks. A slice with 2-bit sub-blocks gives the same results as one with 4-bit sub-blocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_i | input | SUB_W*SUB_CNT | Request vector, index 0 highest priority |
| la_in_i | input | 1 | Lookahead from earlier slices: some higher-priority request exists |
| gnt_o | output | SUB_W*SUB_CNT | One-hot grant vector |
| la_out_o | output | 1 | Lookahead to the next slice |

## Verification
The bench builds three instances. Two use the default split of 4-bit sub-blocks by two and are chained into a 16-bit encoder. The third uses 2-bit sub-blocks by four. The default instance and the 2-bit instance are both swept over all 256 request patterns with each lookahead value. This reaches every combination of lower-half and upper-half requests, and it shows that the choice of split does not change the result. The chained pair is swept over every pattern of the second slice against first-slice patterns that are empty, set only at the first index, set only at the last index, or set in the middle. This exercises how a grant moves across the slice boundary.

// File: rtl/pe_la_pkg.sv
package pe_la_pkg;
   localparam int unsigned PE_SUB_W_DEF   = 4;
   localparam int unsigned PE_SUB_CNT_DEF = 2;

   function automatic int unsigned pe_slice_width(input int unsigned sub_w,
                                                  input int unsigned sub_cnt);
      return sub_w * sub_cnt;
   endfunction
endpackage

// File: rtl/pe_sub_grant.sv
module pe_sub_grant #(
   parameter int unsigned SUB_W = 4
) (
   input  logic [SUB_W-1:0] req_i,
   input  logic             blk_i,
   output logic [SUB_W-1:0] gnt_o
);
   if (SUB_W < 1) begin : g_bad_width
      $error("pe_sub_grant: SUB_W must be at least 1");
   end

   logic [SUB_W-1:0] below_clear;

   for (genvar b = 0; b < SUB_W; b++) begin : g_bit
      if (b == 0) begin : g_first
         assign below_clear[b] = 1'b1;
      end else begin : g_rest
         assign below_clear[b] = ~|req_i[b-1:0];
      end
   end

   assign gnt_o = req_i & below_clear & {SUB_W{~blk_i}};

   always_comb begin
      a_r5_sub_onehot: assert ($onehot0(gnt_o));
      a_r4_sub_blocked: assert (!(blk_i && (gnt_o != '0)));
   end
endmodule

// File: rtl/pe_la_merge.sv
module pe_la_merge #(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0] req_i,
   input  logic         la_i,
   output logic         la_o
);
   if (W < 1) begin : g_bad_width
      $error("pe_la_merge: W must be at least 1");
   end

   assign la_o = la_i | (|req_i);
endmodule

// File: rtl/pe_la_slice.sv
module pe_la_slice
   import pe_la_pkg::*;
#(
   parameter int unsigned SUB_W   = PE_SUB_W_DEF,
   parameter int unsigned SUB_CNT = PE_SUB_CNT_DEF,
   localparam int unsigned SLICE_W = pe_slice_width(SUB_W, SUB_CNT)
) (
   input  logic [SLICE_W-1:0] req_i,
   input  logic               la_in_i,
   output logic [SLICE_W-1:0] gnt_o,
   output logic               la_out_o
);
   if (SUB_CNT < 1) begin : g_bad_count
      $error("pe_la_slice: SUB_CNT must be at least 1");
   end

   // la_chain[k]: some request below sub-block k (or upstream) exists
   logic [SUB_CNT:0] la_chain;
   assign la_chain[0] = la_in_i;

   for (genvar k = 0; k < SUB_CNT; k++) begin : g_sub
      pe_sub_grant #(.SUB_W(SUB_W)) u_grant (
         .req_i (req_i[k*SUB_W +: SUB_W]),
         .blk_i (la_chain[k]),
         .gnt_o (gnt_o[k*SUB_W +: SUB_W])
      );
      pe_la_merge #(.W(SUB_W)) u_merge (
         .req_i (req_i[k*SUB_W +: SUB_W]),
         .la_i  (la_chain[k]),
         .la_o  (la_chain[k+1])
      );
   end

   assign la_out_o = la_chain[SUB_CNT];

   always_comb begin
      // R5: sub-blocks combined still give one grant at most
      a_r5_slice_onehot: assert ($onehot0(gnt_o));
      a_r4_slice_blocked: assert (!(la_in_i && (gnt_o != '0)));
      // R2: a grant implies a pending request downstream sees
      a_r2_grant_raises_la: assert (!((gnt_o != '0) && !la_out_o));
      // R1: an unblocked slice with requests always grants
      a_r1_no_lost_request: assert (!(!la_in_i && (req_i != '0) && (gnt_o == '0)));
   end
endmodule

// File: tb/tb_pe_la_slice.sv
module tb_pe_la_slice;
   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2 clk = ~clk;

   logic [7:0] req_a, req_b, req_c;
   logic       la_a, la_c;
   logic [7:0] gnt_a, gnt_b, gnt_c;
   logic       lo_a, lo_b, lo_c;

   pe_la_slice dut (.req_i(req_a), .la_in_i(la_a), .gnt_o(gnt_a), .la_out_o(lo_a));
   pe_la_slice dut_chain (.req_i(req_b), .la_in_i(lo_a), .gnt_o(gnt_b), .la_out_o(lo_b));
   pe_la_slice #(.SUB_W(2), .SUB_CNT(4)) dut_alt (.req_i(req_c), .la_in_i(la_c),
                                                   .gnt_o(gnt_c), .la_out_o(lo_c));

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] low8(input logic [7:0] x);
      return x & (~x + 8'd1);
   endfunction

   function automatic logic [15:0] low16(input logic [15:0] x);
      return x & (~x + 16'd1);
   endfunction

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      req_a = '0; req_b = '0; req_c = '0; la_a = 1'b0; la_c = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R6 reset grant", {8'h00, gnt_a}, 16'h0000);
      check("R6 reset lookahead", {15'd0, lo_a}, 16'h0000);
      check("R6 alt reset grant", {8'h00, gnt_c}, 16'h0000);
      rst = 1'b0;

      // exhaustive sweep: default split and 2-bit split
      for (int la = 0; la < 2; la++) begin
         for (int v = 0; v < 256; v++) begin
            logic [7:0] x, eg;
            @(posedge clk);
            #1;
            x = 8'(v);
            req_a = x; req_c = x; la_a = la[0]; la_c = la[0];
            @(negedge clk);
            eg = (la != 0) ? 8'h00 : low8(x);
            if (la != 0) check("R4 blocked grant", {8'h00, gnt_a}, 16'h0000);
            else         check("R1 lowest grant", {8'h00, gnt_a}, {8'h00, eg});
            check("R2 lookahead out", {15'd0, lo_a}, {15'd0, (la != 0) || (x != 0)});
            check("R5 one-hot", {15'd0, $countones(gnt_a) <= 1}, 16'h0001);
            if (la == 0 && x[3:0] != 0)
               check("R3 upper half gated", {12'h000, gnt_a[7:4]}, 16'h0000);
            if (la == 0 && x == 0)
               check("R6 idle", {7'd0, lo_a, gnt_a}, 16'h0000);
            check("R8 alt split grant", {8'h00, gnt_c}, {8'h00, eg});
            check("R8 alt split lookahead", {15'd0, lo_c}, {15'd0, lo_a});
         end
      end

      // chained pair
      for (int p = 0; p < 4; p++) begin
         for (int v = 0; v < 256; v++) begin
            logic [7:0] lo;
            logic [15:0] full;
            @(posedge clk);
            #1;
            lo = (p == 0) ? 8'h00 : (p == 1) ? 8'h01 : (p == 2) ? 8'h80 : 8'h18;
            la_a = 1'b0; req_a = lo; req_b = 8'(v);
            full = {8'(v), lo};
            @(negedge clk);
            check("R7 chained grant", {gnt_b, gnt_a}, low16(full));
            check("R7 chained lookahead", {15'd0, lo_b}, {15'd0, full != 0});
         end
      end
      summary();
   end

   initial begin
      #(4 * 200000);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end
endmodule